// File: doc/BRIEF.md
# Parallel Port Byte Download Handshake Controller

The block controls a byte download from a host parallel port into a player buffer. It uses a two-level state machine. The outer level gates the whole transfer. A host request input moves the machine out of idle into a port-ready phase. While the request is held, a ready input starts the inner handshake.

The inner sequencer has three states: player-ready, data-ready and data-acknowledge. It follows the host's active-low strobe, which is synchronized before use, and a next-byte request from the consumer. It drives an active-low acknowledge back to the host. The inner sequence runs only while request and ready are both held. Dropping either one pre-empts the sequence from any inner state.

The data byte is latched as the machine enters data-ready, with a one-cycle valid pulse. A 3-bit state code is exported for observation.

Top module: `ppd_ctrl`

## Requirements
- R1: While reset is held and on its release, state_o is 0 (idle), ack_no is 1, mode_o is 0, ready_o is 0 and byte_valid_o is 0.
- R2: From idle the machine moves to port-ready on the next edge when dl_req_i is 1, and otherwise stays idle.
- R3: In port-ready, dl_req_i at 0 returns the machine to idle. dl_req_i and dl_ready_i both at 1 enter player-ready. Any other input holds port-ready.
- R4: strobe_ni passes through a two-flop synchronizer. Player-ready moves to data-ready on the third rising edge after strobe_ni is sampled low. The machine advances at most one inner state per cycle, so a one-cycle strobe glitch moves it by one state only.
- R5: Data-ready waits while next_req_i is 0. It moves to data-acknowledge on the edge where next_req_i is 1.
- R6: While dl_req_i and dl_ready_i stay 1, data-acknowledge is held at any strobe_ni level.
- R7: In any inner state, dl_req_i at 0 sends the machine to idle. dl_ready_i at 0 with dl_req_i at 1 sends it to port-ready. Either move takes one edge.
- R8: data_i is latched into byte_o on the edge where player-ready moves to data-ready. byte_valid_o is 1 for exactly that following cycle. byte_o holds its value at all other times.
- R9: The outputs are registered and change on the same edge as state_o. ack_no is 0 only in data-acknowledge. mode_o is 1 in every state except idle. ready_o is 1 only in player-ready.
- R10: state_o uses the codes idle=0, port-ready=1, player-ready=2, data-ready=3, data-acknowledge=4. Every state, and both levels of ack_no, mode_o and ready_o, can be reached from the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dl_req_i | input | 1 | Host download request |
| dl_ready_i | input | 1 | Download ready, enables the inner handshake |
| strobe_ni | input | 1 | Host data strobe, active low, asynchronous |
| next_req_i | input | 1 | Consumer asks to acknowledge the current byte |
| data_i | input | DATA_W | Host data bus |
| ack_no | output | 1 | Acknowledge to host, active low |
| mode_o | output | 1 | Download mode active (not idle) |
| ready_o | output | 1 | Player ready to take a strobe |
| byte_o | output | DATA_W | Latched data byte |
| byte_valid_o | output | 1 | One-cycle pulse when byte_o is updated |
| state_o | output | 3 | State code |

## Verification
The hardest cases to reach are the pre-emptions out of the deeper inner states. Data-acknowledge needs a synchronized strobe, then a next-byte request, before request or ready can be dropped. The stimulus walks the full handshake once, drops only ready from data-acknowledge, and re-enters the handshake. It then drops the request from data-ready. It also re-enters player-ready with the strobe already low, so the byte is latched with no extra wait. A separate pass sends a single-cycle strobe glitch together with the next-byte request, to show that the machine takes one state per edge.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
  localparam int unsigned ST_W = 3;
  typedef enum logic [ST_W-1:0] {
    ST_IDLE   = 3'd0,
    ST_PORT   = 3'd1,
    ST_PLAYER = 3'd2,
    ST_DATA   = 3'd3,
    ST_ACK    = 3'd4
  } ppd_state_e;
endpackage

// File: rtl/ppd_sync.sv
module ppd_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= RESET_VAL;
    else         chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= RESET_VAL;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ppd_fsm.sv
module ppd_fsm
  import ppd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       rdy_i,
  input  logic       strb_n_i,
  input  logic       next_i,
  output ppd_state_e state_o,
  output logic       load_o,
  output logic       ack_no,
  output logic       mode_o,
  output logic       ready_o
);
  ppd_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_i) st_d = ST_PORT;
      ST_PORT: begin
        if (!req_i)     st_d = ST_IDLE;
        else if (rdy_i) st_d = ST_PLAYER;
      end
      ST_PLAYER, ST_DATA, ST_ACK: begin
        if (!req_i)      st_d = ST_IDLE;
        else if (!rdy_i) st_d = ST_PORT;
        else begin
          // inner handshake, one step per edge
          unique case (st_q)
            ST_PLAYER: if (!strb_n_i) st_d = ST_DATA;
            ST_DATA:   if (next_i)    st_d = ST_ACK;
            default:   st_d = st_q;
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ack_no  <= 1'b1;
      mode_o  <= 1'b0;
      ready_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      ack_no  <= (st_d != ST_ACK);
      mode_o  <= (st_d != ST_IDLE);
      ready_o <= (st_d == ST_PLAYER);
    end
  end

  assign state_o = st_q;
  assign load_o  = (st_q == ST_PLAYER) && (st_d == ST_DATA);
endmodule

// File: rtl/ppd_capture.sv
module ppd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) byte_o <= data_i;
    end
  end
endmodule

// File: rtl/ppd_ctrl.sv
module ppd_ctrl
  import ppd_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dl_req_i,
  input  logic              dl_ready_i,
  input  logic              strobe_ni,
  input  logic              next_req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_no,
  output logic              mode_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic [ST_W-1:0]   state_o
);
  logic       strb_n_s;
  logic       load;
  ppd_state_e st;

  ppd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (strobe_ni),
    .q_o   (strb_n_s)
  );

  ppd_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (dl_req_i),
    .rdy_i   (dl_ready_i),
    .strb_n_i(strb_n_s),
    .next_i  (next_req_i),
    .state_o (st),
    .load_o  (load),
    .ack_no  (ack_no),
    .mode_o  (mode_o),
    .ready_o (ready_o)
  );

  ppd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (data_i),
    .byte_o (byte_o),
    .valid_o(byte_valid_o)
  );

  assign state_o = st;
endmodule

// File: rtl/ppd_ctrl_chk.sv
module ppd_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dl_req_i,
  input logic              dl_ready_i,
  input logic              next_req_i,
  input logic              ack_no,
  input logic              mode_o,
  input logic              ready_o,
  input logic [DATA_W-1:0] byte_o,
  input logic              byte_valid_o,
  input logic [2:0]        state_o
);
  AST_ACK_ONLY_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_no == 1'b0) == (state_o == 3'd4)); // R9
  AST_MODE_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == (state_o != 3'd0)); // R9
  AST_READY_IN_PLAYER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == (state_o == 3'd2)); // R9
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4); // R10
  AST_IDLE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0) |=> (state_o <= 3'd1)); // R2
  AST_PORT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 && !dl_req_i) |=> (state_o == 3'd0)); // R3
  AST_DATA_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && dl_req_i && dl_ready_i && !next_req_i) |=> (state_o == 3'd3)); // R5
  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && dl_req_i && dl_ready_i) |=> (state_o == 3'd4)); // R6
  AST_DROP_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o >= 3'd2 && !dl_req_i) |=> (state_o == 3'd0)); // R7
  AST_DROP_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o >= 3'd2 && dl_req_i && !dl_ready_i) |=> (state_o == 3'd1)); // R7
  AST_VALID_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && dl_req_i && dl_ready_i) |=> (byte_valid_o == (state_o == 3'd3))); // R8
  AST_BYTE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_o |-> $stable(byte_o)); // R8
endmodule

bind ppd_ctrl ppd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dl_req_i    (dl_req_i),
  .dl_ready_i  (dl_ready_i),
  .next_req_i  (next_req_i),
  .ack_no      (ack_no),
  .mode_o      (mode_o),
  .ready_o     (ready_o),
  .byte_o      (byte_o),
  .byte_valid_o(byte_valid_o),
  .state_o     (state_o)
);

// File: tb/tb_ppd_ctrl.sv
module tb_ppd_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dl_req_i = 1'b0, dl_ready_i = 1'b0, strobe_ni = 1'b1, next_req_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       ack_no, mode_o, ready_o, byte_valid_o;
  logic [7:0] byte_o;
  logic [2:0] state_o;

  int tests = 0, fails = 0, cyc = 0;
  bit seen_st[5];
  bit seen_ack[2], seen_mode[2], seen_rdy[2];

  typedef struct {
    int         due;
    logic [2:0] st;
    logic       v;
    logic [7:0] b;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk_i = ~clk_i;  // 125 MHz
  always @(posedge clk_i) cyc <= cyc + 1;

  ppd_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .dl_req_i(dl_req_i), .dl_ready_i(dl_ready_i),
    .strobe_ni(strobe_ni), .next_req_i(next_req_i), .data_i(data_i),
    .ack_no(ack_no), .mode_o(mode_o), .ready_o(ready_o), .byte_o(byte_o),
    .byte_valid_o(byte_valid_o), .state_o(state_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // outputs implied by a state code (R9)
  task automatic chk_outs(string tag, logic [2:0] st);
    chk(tag, "ack_no",  ack_no,  st != 3'd4);
    chk(tag, "mode_o",  mode_o,  st != 3'd0);
    chk(tag, "ready_o", ready_o, st == 3'd2);
  endtask

  // driver: apply one cycle of inputs, expect the result after the next edge
  task automatic step(logic req, logic rdy, logic strb, logic nxt, logic [7:0] d,
                      logic [2:0] est, logic ev, logic [7:0] eb, string tag);
    exp_t e;
    @(negedge clk_i);
    dl_req_i = req; dl_ready_i = rdy; strobe_ni = strb; next_req_i = nxt; data_i = d;
    e.due = cyc + 1; e.st = est; e.v = ev; e.b = eb; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      seen_st[state_o] = 1'b1;
      seen_ack[ack_no] = 1'b1; seen_mode[mode_o] = 1'b1; seen_rdy[ready_o] = 1'b1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "state_o", state_o, e.st);
        chk_outs(e.tag, e.st);
        chk(e.tag, "byte_valid_o", byte_valid_o, e.v);
        chk(e.tag, "byte_o", byte_o, e.b);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "state_o", state_o, 0);
    chk_outs("R1", 3'd0);
    chk("R1", "byte_valid_o", byte_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "state_o after release", state_o, 0);
    //   req rdy strb nxt data   st  v  byte
    step(0, 0, 1, 0, 8'h00, 3'd0, 0, 8'h00, "R2 hold idle");
    step(1, 0, 1, 0, 8'h00, 3'd1, 0, 8'h00, "R2 enter port");
    step(1, 0, 1, 0, 8'h00, 3'd1, 0, 8'h00, "R3 hold port");
    step(1, 1, 1, 0, 8'h00, 3'd2, 0, 8'h00, "R3 enter player");
    step(1, 1, 0, 0, 8'hA5, 3'd2, 0, 8'h00, "R4 sync stage1");
    step(1, 1, 0, 0, 8'hA5, 3'd2, 0, 8'h00, "R4 sync stage2");
    step(1, 1, 0, 0, 8'hA5, 3'd3, 1, 8'hA5, "R8 capture A5");
    step(1, 1, 1, 0, 8'h00, 3'd3, 0, 8'hA5, "R5 wait next");
    step(1, 1, 1, 1, 8'h00, 3'd4, 0, 8'hA5, "R5 enter ack");
    step(1, 1, 0, 0, 8'h00, 3'd4, 0, 8'hA5, "R6 hold strobe low");
    step(1, 1, 1, 0, 8'h00, 3'd4, 0, 8'hA5, "R6 hold strobe high");
    step(1, 0, 1, 0, 8'h00, 3'd1, 0, 8'hA5, "R7 ready drop from ack");
    step(1, 1, 1, 0, 8'h00, 3'd2, 0, 8'hA5, "R3 reenter player");
    step(1, 1, 0, 0, 8'h3C, 3'd2, 0, 8'hA5, "R4 wait");
    step(1, 1, 0, 0, 8'h3C, 3'd2, 0, 8'hA5, "R4 wait");
    step(1, 1, 0, 0, 8'h3C, 3'd3, 1, 8'h3C, "R8 capture 3C");
    step(0, 1, 0, 0, 8'h77, 3'd0, 0, 8'h3C, "R7 req drop from data");
    step(1, 0, 0, 0, 8'h77, 3'd1, 0, 8'h3C, "R2 enter port");
    step(1, 1, 0, 0, 8'h77, 3'd2, 0, 8'h3C, "R3 enter player");
    step(1, 1, 0, 0, 8'h5A, 3'd3, 1, 8'h5A, "R8 capture with strobe held low");
    step(0, 0, 1, 0, 8'h00, 3'd0, 0, 8'h5A, "R7 both drop");
    step(1, 1, 1, 0, 8'h00, 3'd1, 0, 8'h5A, "R2 enter port");
    step(1, 1, 1, 0, 8'h00, 3'd2, 0, 8'h5A, "R3 enter player");
    step(1, 1, 1, 0, 8'h00, 3'd2, 0, 8'h5A, "R4 idle strobe");
    step(1, 1, 0, 1, 8'hC3, 3'd2, 0, 8'h5A, "R4 glitch low");
    step(1, 1, 1, 1, 8'hC3, 3'd2, 0, 8'h5A, "R4 glitch in sync");
    step(1, 1, 1, 1, 8'hC3, 3'd3, 1, 8'hC3, "R4 one step only");
    step(1, 1, 1, 1, 8'h00, 3'd4, 0, 8'hC3, "R5 enter ack");
    step(0, 1, 1, 0, 8'h00, 3'd0, 0, 8'hC3, "R7 req drop from ack");
    step(1, 0, 1, 0, 8'h00, 3'd1, 0, 8'hC3, "R2 enter port");
    step(0, 0, 1, 0, 8'h00, 3'd0, 0, 8'hC3, "R3 drop from port");
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 5; i++) chk("R10", "state reached", seen_st[i], 1);
    for (int i = 0; i < 2; i++) begin
      chk("R10", "ack_no level", seen_ack[i], 1);
      chk("R10", "mode_o level", seen_mode[i], 1);
      chk("R10", "ready_o level", seen_rdy[i], 1);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule